// File: doc/BRIEF.md
# Serial Memory Command Front End with Status-Register Write Protection

This block is the serial slave front end of a nonvolatile memory. It samples the serial clock, select, data, hold and write-protect pins with the system clock and assembles command frames. It also decodes the one-byte opcode that opens each frame and keeps the status register. The block does not hold the memory array. A write that the block accepts is passed to an external write engine as a request, and the engine answers with a done pulse when its internal write cycle ends.

Writes to the status register are guarded at two levels. A write-enable latch has to be set by an earlier command. A hardware protect pin takes part only when the protect-enable bit in the status register is set. A write is launched only when the select line returns high after a whole number of bytes. The protect check covers the whole frame up to that moment, and once the request is out it is left alone.

Top module: `sr_protect_spi`

## Requirements
- R1: SI is sampled on rising SCK, most significant bit first, and SO changes only after falling SCK. After opcode 05h, SO returns the status byte {WPEN, 5'b0, WEL, WIP} with bit 7 first, and so_oe is high during that data phase.
- R2: While cs_n is high, and out of reset, so_oe is low and SO reads 0.
- R3: After reset no frame is acted on until cs_n has gone from high to low. A frame that is already selected when reset is released is ignored.
- R4: Opcode 06h sets WEL (status bit 1) and opcode 04h clears it. Each takes effect at the rising cs_n edge, and only when the frame held exactly 8 bits.
- R5: Opcode 01h (status write, one data byte) and opcode 02h (array write, 2 address bytes then at least one data byte) launch only when WEL is 1 and the frame ends on a byte boundary. A partial byte or a missing byte cancels them.
- R6: A launched write raises wr_req, sets WIP (status bit 0), and sets wr_status high for a status write and low for an array write. wr_req stays up until wr_done. WEL then clears, and a status write then copies data bit 7 into WPEN (status bit 7).
- R7: With WPEN = 1 and wp_n low, a status write is refused and WEL stays set. Array writes are unaffected.
- R8: With WPEN = 0, wp_n is ignored and a status write with wp_n low proceeds.
- R9: With WPEN = 1, wp_n going low at any point while cs_n is low in a status-write frame cancels that write, even if wp_n is high again before cs_n rises.
- R10: Once a status write has launched, wp_n going low does not cancel it, and WPEN takes the written value at wr_done.
- R11: While hold_n is low, SCK edges are ignored and so_oe is low. The frame resumes where it stopped when hold_n returns high.
- R12: While WIP is 1, only opcode 05h is acted on. Opcodes 06h, 04h, 01h and 02h have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Slave select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| wp_n | input | 1 | Hardware write protect, active low |
| hold_n | input | 1 | Pause of the serial interface, active low |
| wr_done | input | 1 | Pulse from the write engine that ends the internal write |
| so | output | 1 | Serial data out (0 when not enabled) |
| so_oe | output | 1 | Output enable for SO; low means high impedance |
| wr_req | output | 1 | Internal write request, held until wr_done |
| wr_status | output | 1 | High when the pending write targets the status register |

## Verification
The hardest case is a protect-pin pulse that starts and ends inside one selected status-write frame, before cs_n rises. At the moment of launch the pin reads high, so only a design that remembers the pulse refuses the write. The bench drops wp_n for a few cycles between two data bits of the frame. It also drops wp_n while a launched write waits for wr_done, which shows that only the window before launch counts. The write engine's done pulse is driven by hand, so status reads and ignored commands can be issued while WIP is held at 1.

// File: rtl/sr_protect_spi.sv
module sr_protect_spi #(
  parameter int         ADDR_BYTES = 2,
  parameter logic [7:0] OP_WREN    = 8'h06,
  parameter logic [7:0] OP_WRDI    = 8'h04,
  parameter logic [7:0] OP_RDSR    = 8'h05,
  parameter logic [7:0] OP_WRSR    = 8'h01,
  parameter logic [7:0] OP_WRITE   = 8'h02
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic wp_n,
  input  logic hold_n,
  input  logic wr_done,
  output logic so,
  output logic so_oe,
  output logic wr_req,
  output logic wr_status
);
  localparam int MAXB = ADDR_BYTES + 2;
  localparam int BW   = $clog2(MAXB + 1);

  logic [1:0] cs_m, sck_m, si_m, hold_m, wp_m;
  logic cs_q, sck_q;
  logic armed, wel, wpen, wp_blk, so_q;
  logic [2:0] bitcnt, ridx;
  logic [BW-1:0] bytecnt;
  logic [7:0] sh, op, sr_new, sr_hold;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_m <= 2'b00; cs_q <= 1'b0;
      sck_m <= 2'b00; sck_q <= 1'b0;
      si_m <= 2'b00; hold_m <= 2'b11; wp_m <= 2'b11;
    end else begin
      cs_m <= {cs_m[0], cs_n}; cs_q <= cs_m[1];
      sck_m <= {sck_m[0], sck}; sck_q <= sck_m[1];
      si_m <= {si_m[0], si}; hold_m <= {hold_m[0], hold_n}; wp_m <= {wp_m[0], wp_n};
    end

  wire cs_fall  = cs_q & ~cs_m[1];
  wire cs_rise  = ~cs_q & cs_m[1];
  wire sck_rise = sck_m[1] & ~sck_q;
  wire sck_fall = ~sck_m[1] & sck_q;
  wire sel      = armed & ~cs_m[1];
  wire act      = sel & hold_m[1];
  wire [7:0] byte_in = {sh[6:0], si_m[1]};
  wire [7:0] status  = {wpen, 5'b0, wel, wr_req};
  wire rd_phase = (bytecnt != '0) && (op == OP_RDSR);
  wire whole    = (bitcnt == 3'd0);
  wire op_only  = whole && (bytecnt == BW'(1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      armed <= 1'b0; bitcnt <= '0; bytecnt <= '0; ridx <= '0;
      sh <= '0; op <= '0; sr_new <= '0; so_q <= 1'b0; wp_blk <= 1'b0;
    end else begin
      if (cs_fall) begin
        armed <= 1'b1; bitcnt <= '0; bytecnt <= '0; ridx <= '0;
        so_q <= 1'b0; wp_blk <= 1'b0;
      end else if (act && sck_rise) begin
        sh <= byte_in;
        bitcnt <= bitcnt + 3'd1;
        if (bitcnt == 3'd7) begin
          if (bytecnt == '0) op <= byte_in;
          if (bytecnt == BW'(1)) sr_new <= byte_in;
          if (bytecnt != BW'(MAXB)) bytecnt <= bytecnt + BW'(1);
        end
      end else if (act && sck_fall && rd_phase) begin
        so_q <= status[3'd7 - ridx];
        ridx <= ridx + 3'd1;
      end
      if (sel && wpen && !wp_m[1]) wp_blk <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_req <= 1'b0; wr_status <= 1'b0; wel <= 1'b0; wpen <= 1'b0; sr_hold <= '0;
    end else if (wr_req) begin
      if (wr_done) begin
        wr_req <= 1'b0;
        wel <= 1'b0;
        if (wr_status) wpen <= sr_hold[7];
      end
    end else if (cs_rise && armed) begin
      if (op_only && op == OP_WREN) wel <= 1'b1;
      if (op_only && op == OP_WRDI) wel <= 1'b0;
      if (wel && whole && op == OP_WRSR && bytecnt >= BW'(2) && !wp_blk) begin
        wr_req <= 1'b1; wr_status <= 1'b1; sr_hold <= sr_new;
      end
      if (wel && whole && op == OP_WRITE && bytecnt >= BW'(MAXB)) begin
        wr_req <= 1'b1; wr_status <= 1'b0;
      end
    end

  assign so_oe = act & rd_phase;
  assign so    = so_oe & so_q;

  // R2
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_m[1] && cs_q |-> !so_oe && !so);
  // R11
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_m[1] |-> !so_oe);
  // R6
  done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && wr_done |=> !wr_req && !wel);
  // R12
  busy_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !wr_done |=> $stable(wel) && $stable(wpen));
  // R10
  launch_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !wr_done |=> wr_req && $stable(wr_status));
  // R3
  unarmed_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !wr_req && !wel && !so_oe);
endmodule

// File: tb/test_sr_protect_spi.sv
module test_sr_protect_spi;
  logic clk = 0, rst_n = 0, cs_n = 0, sck = 0, si = 0, wp_n = 1, hold_n = 1, wr_done = 0;
  logic so, so_oe, wr_req, wr_status;
  int n_run = 0, n_fail = 0;
  localparam int H = 6;
  typedef struct { string tag; logic [7:0] val; } item_t;
  item_t exp_q[$];
  logic [7:0] got_q[$];

  always #4 clk = ~clk;

  sr_protect_spi i_sr_protect_spi (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .wp_n(wp_n), .hold_n(hold_n), .wr_done(wr_done), .so(so), .so_oe(so_oe),
    .wr_req(wr_req), .wr_status(wr_status));

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk)
    if (exp_q.size() > 0 && got_q.size() > 0) begin
      item_t e;
      logic [7:0] g;
      e = exp_q.pop_front();
      g = got_q.pop_front();
      check(e.tag, g, e.val);
    end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    si = b; tick(H); sck = 1; tick(H); sck = 0;
  endtask

  task automatic send(input logic [7:0] b, input int n = 8);
    for (int i = 7; i > 7 - n; i--) bit_out(b[i]);
  endtask

  task automatic sel_on();
    cs_n = 0; tick(H);
  endtask

  task automatic sel_off();
    tick(H); cs_n = 1; tick(10);
  endtask

  task automatic cmd1(input logic [7:0] a);
    sel_on(); send(a); sel_off();
  endtask

  task automatic cmd2(input logic [7:0] a, input logic [7:0] b);
    sel_on(); send(a); send(b); sel_off();
  endtask

  task automatic rdsr(input string tag, input logic [7:0] expv);
    item_t e;
    logic [7:0] r;
    e.tag = tag; e.val = expv;
    exp_q.push_back(e);
    sel_on(); send(8'h05);
    for (int i = 0; i < 8; i++) begin
      tick(H); r = {r[6:0], so}; sck = 1; tick(H); sck = 0;
    end
    sel_off();
    got_q.push_back(r);
    tick(2);
  endtask

  task automatic finish_write();
    wr_done = 1; tick(1); wr_done = 0; tick(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    tick(5); rst_n = 1; tick(3);
    check("R2 reset so_oe", so_oe, 0);
    check("R3 reset wr_req", wr_req, 0);
    send(8'h06); sel_off();
    rdsr("R3 frame selected at reset ignored", 8'h00);

    cmd1(8'h06); rdsr("R4 WREN sets WEL", 8'h02);
    cmd1(8'h04); rdsr("R4 WRDI clears WEL", 8'h00);
    sel_on(); send(8'h06); send(8'h00, 1); sel_off();
    rdsr("R4 WREN with 9 bits ignored", 8'h00);
    check("R2 deselected so_oe", so_oe, 0);

    cmd2(8'h01, 8'h80);
    check("R5 status write without WEL", wr_req, 0);
    cmd1(8'h06);
    sel_on(); send(8'h01); send(8'h80, 7); sel_off();
    check("R5 partial status byte", wr_req, 0);
    rdsr("R5 WEL kept after partial", 8'h02);

    cmd2(8'h01, 8'h80);
    check("R6 status write launched", wr_req, 1);
    check("R6 target is status", wr_status, 1);
    rdsr("R6 WIP during write", 8'h03);
    cmd1(8'h04);
    rdsr("R12 WRDI ignored while busy", 8'h03);
    finish_write();
    check("R6 request dropped", wr_req, 0);
    rdsr("R6 WPEN written, WEL cleared", 8'h80);

    wp_n = 0;
    cmd1(8'h06);
    cmd2(8'h01, 8'h00);
    check("R7 protected status write refused", wr_req, 0);
    rdsr("R7 WPEN and WEL kept", 8'h82);
    sel_on(); send(8'h02); send(8'h00); send(8'h10); send(8'hA5); sel_off();
    check("R7 array write allowed", wr_req, 1);
    check("R7 target is array", wr_status, 0);
    finish_write();
    rdsr("R7 after array write", 8'h80);

    wp_n = 1;
    cmd1(8'h06);
    sel_on(); send(8'h01); send(8'h00, 4); wp_n = 0; tick(4); wp_n = 1; send(8'h00 << 4, 4); sel_off();
    check("R9 pulse on wp cancels", wr_req, 0);
    rdsr("R9 state after cancel", 8'h82);

    cmd2(8'h01, 8'h00);
    check("R10 launched", wr_req, 1);
    wp_n = 0; tick(10);
    check("R10 wp after launch ignored", wr_req, 1);
    finish_write();
    rdsr("R10 WPEN cleared by write", 8'h00);

    cmd1(8'h06);
    cmd2(8'h01, 8'h00);
    check("R8 wp ignored with WPEN clear", wr_req, 1);
    finish_write();
    wp_n = 1;

    sel_on(); send(8'h06 >> 4 << 4, 4);
    hold_n = 0; tick(H); bit_out(1); bit_out(1); bit_out(1);
    hold_n = 1; tick(H); send(8'h06 << 4, 4); sel_off();
    rdsr("R11 frame resumes after hold", 8'h02);
    sel_on(); send(8'h05); tick(H);
    check("R1 so_oe in read phase", so_oe, 1);
    hold_n = 0; tick(H);
    check("R11 so_oe low in hold", so_oe, 0);
    hold_n = 1; sel_off();

    sel_on(); send(8'h02); send(8'h00); send(8'h10); send(8'hFF, 5); sel_off();
    check("R5 partial data byte", wr_req, 0);
    sel_on(); send(8'h02); send(8'h00); send(8'h10); sel_off();
    check("R5 no data byte", wr_req, 0);
    rdsr("R1 status bits in order", 8'h02);

    tick(20);
    if (exp_q.size() != 0) begin
      n_run++; n_fail++;
      $display("FAIL scoreboard: got %0d leftover expected 0", exp_q.size());
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule